// File: doc/BRIEF.md
# Matrix Key Encoder with Read-Clear Holding Register

This block turns a key grid into a 7-bit key number and holds that number for a processor. Every key, when pressed, closes two contacts together: one on a bank of 4 row lines and one on a bank of 16 column lines. A priority encoder on each bank produces a field. The row field forms the upper 3 bits and the column field forms the lower 4 bits. The row field is zero only when no row line is active, so a zero there marks "no key".

When a key goes down, the combined number is loaded into a holding register and a valid flag is set. The register keeps its value after release, until a later key replaces it. The processor reads the register at one fixed address of a simple read port and receives the valid flag together with the number. The read clears the flag but leaves the number in place. A level interrupt request stays high for as long as an unread key is held in the register.

Top module: `keyMatrixLatch`

## Requirements
- R1: Bits 6:4 of the key number equal one plus the index of the lowest-numbered active row line (row 0 gives 1, row 3 gives 4). With no row line active these bits are 0.
- R2: Bits 3:0 of the key number equal the index of the lowest-numbered active column line.
- R3: A key is loaded only in a cycle where some row line is active and no row line was active in the previous cycle. The new number and a set valid flag are visible from the next cycle. Column activity with no row line active loads nothing.
- R4: While any row line stays active, changes on the lines do not reload the register.
- R5: After release, the stored number stays unchanged for any number of cycles until the next load.
- R6: A read with the read enable high and the address equal to 0x40 returns {valid, key number} in the same cycle, with valid in bit 7.
- R7: Such a read clears the valid flag at the next clock edge and leaves the key number unchanged.
- R8: A read at any other address returns 0 and leaves the valid flag unchanged.
- R9: When a load and a read fall in the same cycle, the read returns the previous contents and the new key wins: valid is set afterwards and holds the new number.
- R10: The interrupt request is high exactly when the valid flag is set.
- R11: After reset the read value is 0 and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rowLines | input | 4 | Row contact bank, one bit per line |
| colLines | input | 16 | Column contact bank, one bit per line |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Read address |
| rdData | output | 8 | Read result {valid, key number} or 0 |
| irq | output | 1 | Level interrupt request |

## Verification
A key load and a clearing read can fall in the same cycle. The bench provokes this by releasing every key, then in one cycle pressing a new key while reading the device address. It then checks that the read in that cycle shows the old, already cleared contents, and that on the following cycle the interrupt is high and a read returns the new number with valid set. A cycle-by-cycle behavioural model also judges every other cycle, including reads that are held over several loads.

// File: rtl/keyMatrixPkg.sv
package keyMatrixPkg;
  typedef struct packed {
    logic capture;
    logic clearValid;
  } keyStrobes_t;
endpackage

// File: rtl/priorityEnc.sv
module priorityEnc #(
  parameter int N = 4,
  parameter int W = 3,
  parameter int OFFSET = 1
) (
  input  logic [N-1:0] lines,
  output logic [W-1:0] code,
  output logic         hit
);
  always_comb begin
    code = '0;
    hit  = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lines[i]) begin
        code = W'(i + OFFSET);
        hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyCtrl.sv
module keyCtrl
  import keyMatrixPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              anyKey,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output keyStrobes_t       strobes,
  output logic              rdHit
);
  logic prevAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevAny <= 1'b0;
    else        prevAny <= anyKey;
  end

  assign rdHit              = rdEn && (rdAddr == DEV_ADDR);
  assign strobes.capture    = anyKey && !prevAny;
  assign strobes.clearValid = rdHit;
endmodule

// File: rtl/keyDatapath.sv
module keyDatapath
  import keyMatrixPkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  keyStrobes_t       strobes,
  input  logic [CODE_W-1:0] newCode,
  input  logic              rdHit,
  output logic [CODE_W:0]   rdData,
  output logic              irq
);
  logic [CODE_W-1:0] keyCode;
  logic              valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keyCode <= '0;
      valid   <= 1'b0;
    end else if (strobes.capture) begin
      keyCode <= newCode;
      valid   <= 1'b1;
    end else if (strobes.clearValid) begin
      valid   <= 1'b0;
    end
  end

  assign rdData = rdHit ? {valid, keyCode} : '0;
  assign irq    = valid;

  // R3: a load shows the encoded number with valid set on the next cycle
  p_capture_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.capture |=> (valid && keyCode == $past(newCode)));

  // R7: a read without a competing load drops valid and keeps the number
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clearValid && !strobes.capture) |=> (!valid && $stable(keyCode)));

  // R5: without a load the stored number never moves
  p_code_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(keyCode));
endmodule

// File: rtl/keyMatrixLatch.sv
module keyMatrixLatch
  import keyMatrixPkg::*;
#(
  parameter int ROW_N = 4,
  parameter int COL_N = 16,
  parameter int ROW_W = $clog2(ROW_N + 1),
  parameter int COL_W = $clog2(COL_N),
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ROW_N-1:0]       rowLines,
  input  logic [COL_N-1:0]       colLines,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [ROW_W+COL_W:0]   rdData,
  output logic                   irq
);
  localparam int CODE_W = ROW_W + COL_W;

  logic [ROW_W-1:0] rowCode;
  logic [COL_W-1:0] colCode;
  logic             rowHit;
  logic             colHit;
  logic             rdHit;
  keyStrobes_t      strobes;

  priorityEnc #(.N(ROW_N), .W(ROW_W), .OFFSET(1)) u_rowEnc (
    .lines(rowLines), .code(rowCode), .hit(rowHit)
  );

  priorityEnc #(.N(COL_N), .W(COL_W), .OFFSET(0)) u_colEnc (
    .lines(colLines), .code(colCode), .hit(colHit)
  );

  keyCtrl #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyKey(rowHit),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobes(strobes), .rdHit(rdHit)
  );

  keyDatapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .newCode({rowCode, colCode}), .rdHit(rdHit),
    .rdData(rdData), .irq(irq)
  );

  logic unusedColHit;
  assign unusedColHit = colHit;

  // R10: an unread key keeps the request up until a read at the device address
  p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rdEn && rdAddr == DEV_ADDR)) |=> irq);
endmodule

// File: tb/test_keyMatrixLatch.sv
module test_keyMatrixLatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rowLines = '0;
  logic [15:0] colLines = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int refValid = 0;
  int refCode = 0;
  int refPrev = 0;

  always #5 clk = ~clk;

  keyMatrixLatch i_keyMatrixLatch (
    .clk(clk), .rst_n(rst_n), .rowLines(rowLines), .colLines(colLines),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic int encodeKey(logic [3:0] r, logic [15:0] c);
    int hi = 0;
    int lo = 0;
    for (int i = 3; i >= 0; i--) if (r[i]) hi = i + 1;
    for (int j = 15; j >= 0; j--) if (c[j]) lo = j;
    return hi * 16 + lo;
  endfunction

  function automatic int expRead();
    if (rdEn && rdAddr == 8'h40) return refValid * 128 + refCode;
    return 0;
  endfunction

  // behavioural reference, stepped on every edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refValid = 0; refCode = 0; refPrev = 0;
    end else begin
      int anyNow;
      anyNow = (rowLines != 0) ? 1 : 0;
      if (anyNow == 1 && refPrev == 0) begin
        refCode  = encodeKey(rowLines, colLines);
        refValid = 1;
      end else if (rdEn && rdAddr == 8'h40) begin
        refValid = 0;
      end
      refPrev = anyNow;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock (R6 read value, R10 request)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 model read", int'(rdData), expRead());
      check("R10 model irq", int'(irq), refValid);
    end
  end

  task automatic nextCycle();
    @(negedge clk);
    #2;
  endtask

  task automatic drive(logic [3:0] r, logic [15:0] c, logic re, logic [7:0] a);
    rowLines = r; colLines = c; rdEn = re; rdAddr = a;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nextCycle();
    nextCycle();
    rst_n = 1'b1;
    nextCycle();

    // R11: reset state
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R11 reset read", int'(rdData), 0);
    check("R11 reset irq", int'(irq), 0);
    nextCycle();

    // R3: column alone loads nothing
    drive(4'b0, 16'h0100, 1'b0, 8'h40);
    nextCycle();
    check("R3 column only no irq", int'(irq), 0);

    // R1 R2 R3: row 2, column 5 -> 0x35
    drive(4'b0100, 16'h0020, 1'b0, 8'h40);
    nextCycle();
    check("R10 irq after press", int'(irq), 1);
    // R4: change lines while held
    drive(4'b0001, 16'h0200, 1'b0, 8'h40);
    nextCycle();
    drive(4'b0001, 16'h0200, 1'b1, 8'h40);
    check("R1 R2 R6 read 0x35 with valid", int'(rdData), 8'hB5);
    nextCycle();
    check("R4 no reload while held", int'(rdData), 8'h35);
    check("R7 valid cleared", int'(irq), 0);

    // R5: release and wait
    drive(4'b0, 16'b0, 1'b0, 8'h40);
    repeat (10) nextCycle();
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R5 code kept after release", int'(rdData), 8'h35);
    nextCycle();

    // R1 R2 priority: rows 1 and 3, columns 3 and 12 -> 0x23
    drive(4'b1010, 16'h1008, 1'b0, 8'h40);
    nextCycle();
    // R8: other address
    drive(4'b1010, 16'h1008, 1'b1, 8'h41);
    check("R8 other address reads 0", int'(rdData), 0);
    nextCycle();
    check("R8 valid kept", int'(irq), 1);
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R1 R2 lowest line wins", int'(rdData), 8'hA3);
    nextCycle();

    // R1 R2 extremes: row 3 col 15 -> 0x4F, row 0 col 0 -> 0x10
    drive(4'b1000, 16'h8000, 1'b0, 8'h40);
    nextCycle();
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R1 R2 row3 col15", int'(rdData), 8'hCF);
    nextCycle();
    drive(4'b0001, 16'h0001, 1'b0, 8'h40);
    nextCycle();
    drive(4'b0, 16'b0, 1'b0, 8'h40);
    nextCycle();
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R1 R2 row0 col0", int'(rdData), 8'h90);
    nextCycle();

    // R9: load and read in the same cycle -> new key 0x27 wins
    drive(4'b0010, 16'h0080, 1'b1, 8'h40);
    check("R9 read shows old contents", int'(rdData), 8'h10);
    nextCycle();
    drive(4'b0010, 16'h0080, 1'b0, 8'h40);
    check("R9 irq after collision", int'(irq), 1);
    nextCycle();
    drive(4'b0, 16'b0, 1'b1, 8'h40);
    check("R9 new key held", int'(rdData), 8'hA7);
    nextCycle();
    drive(4'b0, 16'b0, 1'b0, 8'h00);
    nextCycle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule